// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Engine

This block is the target side of a two-wire serial memory that serves read traffic. It oversamples the clock and data lines with the system clock and sees the start, repeated-start and stop conditions. It matches a fixed 4-bit device code in the address byte. It pulls the data line low through an output-enable and never drives it high. A 128-byte array inside the block holds the contents. A separate load port fills the array for test.

One shared word pointer controls which byte comes out. A read advances the pointer past the byte it returned. A write that only supplies a word address loads the pointer and leaves it there. A host can do three things:
- read from wherever the pointer stands (current-address read);
- set the pointer with a short write and then issue a repeated start (random read);
- keep acknowledging to stream bytes in order; the stream wraps from the top of the array to the bottom.

Top module: `i2c_mem_reader`

## Requirements
- R1: After reset the block does not drive SDA, and the pointer is 0, so the first current-address read returns the byte at address 0.
- R2: The address byte is accepted only when its bits 7:4 equal 4'b1010. Bits 3:1 are ignored. Bit 0 selects the direction (1 = read, 0 = write). A byte with any other code is not acknowledged, and SDA stays released until the next START.
- R3: After an accepted address byte, and after a word-address byte, the block drives SDA low for the whole ninth SCL pulse.
- R4: In a write, bits 6:0 of the byte after the address byte load the pointer; bit 7 of that byte is ignored. A repeated START followed by a read then returns the byte at that address.
- R5: Data bytes go out most significant bit first. Each bit is valid while SCL is high.
- R6: A read that returned the byte at address n leaves the pointer at n+1, so the next current-address read returns byte n+1.
- R7: A write that ends with STOP right after the word-address acknowledge leaves the pointer at that address and does not modify the array.
- R8: When the host acknowledges a data byte (SDA low on the ninth pulse), the next byte follows. Address 127 is followed by address 0.
- R9: When the host does not acknowledge a data byte, the block releases SDA and drives nothing until the next START. The pointer rests one past the last byte sent.
- R10: A START or STOP in the middle of a byte abandons the transfer. A STOP returns the block to idle with SDA released. A START begins a new address byte. A word-address byte cut short does not change the pointer.
- R11: The block changes its SDA drive only while SCL is low.
- R12: In a write, bytes after the word address are not acknowledged and do not modify the array.
- R13: A write on the load port (load_we high for one clock) stores load_data at load_addr, and a later bus read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| load_we | input | 1 | Load-port write strobe |
| load_addr | input | 7 | Load-port byte address |
| load_data | input | 8 | Load-port byte value |

## Verification
Most internal faults show up at the ports quickly:
- A wrong pointer shows up as the wrong byte on the very next read. The scenarios are chained so that each read depends on where the previous transfer left the pointer: after reads, after dummy writes, after wraparound and after aborted bytes.
- A bit-counter error or a wrong shift direction corrupts the byte being sent, or moves the acknowledge off the ninth pulse, within that byte.
- A state error after a refused address, a refused data byte or a NACK appears as SDA held low where the host reads ones. The bench samples the line on those clocks.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } rd_state_e;
endpackage

// File: rtl/i2c_rd_line_sync.sv
module i2c_rd_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  // Both lines pass through equal-length chains so their relative order is kept.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[MSB];
      sda_d    <= sda_pipe[MSB];
    end
  end

  assign scl_s     = scl_pipe[MSB];
  assign sda_s     = sda_pipe[MSB];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
  import i2c_rd_pkg::*;
#(
  parameter int          AW       = 7,
  parameter int          DW       = 8,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          sda_oe
);
  localparam int            CW     = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL   = CW'(DW);
  localparam logic [CW-1:0] LASTTX = CW'(DW - 1);

  rd_state_e     state;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] shreg, txsh;
  logic [AW-1:0] cnt;
  logic          rw, mack, oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txsh   <= '0;
      cnt    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      oe     <= 1'b0;
    end else if (start_det) begin
      state  <= ST_DEV;
      bitcnt <= '0;
      oe     <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      oe     <= 1'b0;
    end else begin
      if (scl_rise) begin
        if (state == ST_DEV || state == ST_WADDR) begin
          shreg  <= {shreg[DW-2:0], sda_s};
          bitcnt <= bitcnt + CW'(1);
        end
        if (state == ST_TX_ACK) mack <= ~sda_s;
      end
      if (scl_fall) begin
        case (state)
          ST_DEV: if (bitcnt == FULL) begin
            bitcnt <= '0;
            if (shreg[DW-1 -: 4] == DEV_CODE) begin
              rw    <= shreg[0];
              oe    <= 1'b1;
              state <= ST_DEV_ACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_DEV_ACK: if (rw) begin
            txsh   <= rd_data;
            oe     <= ~rd_data[DW-1];
            cnt    <= cnt + AW'(1);
            bitcnt <= '0;
            state  <= ST_TX;
          end else begin
            oe    <= 1'b0;
            state <= ST_WADDR;
          end
          ST_WADDR: if (bitcnt == FULL) begin
            cnt    <= shreg[AW-1:0];
            oe     <= 1'b1;
            bitcnt <= '0;
            state  <= ST_WADDR_ACK;
          end
          ST_WADDR_ACK: begin
            oe    <= 1'b0;
            state <= ST_IGNORE;
          end
          ST_TX: if (bitcnt == LASTTX) begin
            oe    <= 1'b0;
            state <= ST_TX_ACK;
          end else begin
            bitcnt <= bitcnt + CW'(1);
            txsh   <= txsh << 1;
            oe     <= ~txsh[DW-2];
          end
          ST_TX_ACK: if (mack) begin
            txsh   <= rd_data;
            oe     <= ~rd_data[DW-1];
            cnt    <= cnt + AW'(1);
            bitcnt <= '0;
            state  <= ST_TX;
          end else begin
            state <= ST_IGNORE;
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr = cnt;
  assign sda_oe  = oe;

  AST_DRIVE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> !$past(scl_s)); // R11
  AST_RELEASED_WHEN_PASSIVE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_IGNORE) |-> !oe); // R9
  AST_POINTER_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cnt) && $past(state) != ST_WADDR) |-> cnt == AW'($past(cnt) + AW'(1))); // R6
  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= FULL); // R5
endmodule

// File: rtl/i2c_mem_reader.sv
module i2c_mem_reader #(
  parameter int         AW          = 7,
  parameter int         DW          = 8,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          load_we,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  i2c_rd_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rd_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .wr_en(load_we), .wr_addr(load_addr), .wr_data(load_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  i2c_rd_fsm #(.AW(AW), .DW(DW), .DEV_CODE(DEV_CODE)) u_fsm (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_addr(rd_addr), .sda_oe(sda_oe)
  );
endmodule

// File: tb/i2c_mem_reader_tb.sv
module i2c_mem_reader_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic load_we = 1'b0;
  logic [6:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic sda_oe;
  logic sda_line;
  int n_chk = 0;
  int n_fail = 0;
  int oe_viol = 0;
  logic oe_prev = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_mem_reader u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .load_we(load_we), .load_addr(load_addr), .load_data(load_data)
  );

  // R11 monitor: any change of drive must happen while SCL is low
  always @(posedge clk) begin
    oe_prev <= sda_oe;
    if (!rst && sda_oe != oe_prev && scl_m) oe_viol <= oe_viol + 1;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    if (scl_m) begin
      sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
    end else begin
      sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
      sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
    end
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; hold(); scl_m = 1'b1; hold(); hold(); scl_m = 1'b0; hold();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); b = sda_line; hold(); scl_m = 1'b0; hold();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(~host_ack);
  endtask

  task automatic mem_load(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    load_we = 1'b1; load_addr = a; load_data = d;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic cur_read(input logic [7:0] exp, input string req);
    logic ack;
    logic [7:0] v;
    bus_start();
    send_byte(8'hA1, ack);
    chk(ack, "R3 read address ack", 32'(ack), 1);
    recv_byte(1'b0, v);
    chk(v == exp, req, 32'(v), 32'(exp));
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] wa, input logic [7:0] exp, input string req);
    logic ack;
    logic [7:0] v;
    bus_start();
    send_byte(8'hA0, ack);
    chk(ack, "R3 write address ack", 32'(ack), 1);
    send_byte(wa, ack);
    chk(ack, "R3 word address ack", 32'(ack), 1);
    bus_start();
    send_byte(8'hA1, ack);
    chk(ack, "R3 read address ack", 32'(ack), 1);
    recv_byte(1'b0, v);
    chk(v == exp, req, 32'(v), 32'(exp));
    bus_stop();
  endtask

  task automatic t_reset_and_current();
    chk(sda_oe == 1'b0, "R1 released after reset", 32'(sda_oe), 0);
    cur_read(pat(0), "R1 first current read at 0");
    cur_read(pat(1), "R6 current read advances");
  endtask

  task automatic t_random();
    rand_read(8'h35, pat(8'h35), "R4 random read");
    rand_read(8'hB5, pat(8'h35), "R4 word bit7 ignored");
  endtask

  task automatic t_dummy_write();
    logic ack;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h10, ack);
    bus_stop();
    cur_read(pat(8'h10), "R7 pointer kept after dummy write");
    cur_read(pat(8'h11), "R7 array unchanged next byte");
  endtask

  task automatic t_sequential();
    logic ack;
    logic [7:0] v;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h7E, ack);
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(1'b1, v); chk(v == pat(126), "R8 seq byte 126", 32'(v), 32'(pat(126)));
    recv_byte(1'b1, v); chk(v == pat(127), "R8 seq byte 127", 32'(v), 32'(pat(127)));
    recv_byte(1'b1, v); chk(v == pat(0), "R8 wrap to 0", 32'(v), 32'(pat(0)));
    recv_byte(1'b0, v); chk(v == pat(1), "R5 R8 byte after wrap", 32'(v), 32'(pat(1)));
    bus_stop();
    chk(sda_oe == 1'b0, "R9 released after NACK", 32'(sda_oe), 0);
    cur_read(pat(2), "R9 pointer after NACK");
  endtask

  task automatic t_device_code();
    logic ack;
    logic b;
    logic [8:0] seen;
    bus_start();
    send_byte(8'hAF, ack);
    chk(ack, "R2 dont-care bits accepted", 32'(ack), 1);
    recv_byte(1'b0, seen[7:0]);
    chk(seen[7:0] == pat(3), "R2 read with dont-care bits", 32'(seen[7:0]), 32'(pat(3)));
    bus_stop();
    bus_start();
    send_byte(8'hB1, ack);
    chk(!ack, "R2 wrong code not acked", 32'(ack), 0);
    for (int i = 8; i >= 0; i--) begin
      bit_in(b);
      seen[i] = b;
    end
    chk(seen == 9'h1FF, "R2 silent after wrong code", 32'(seen), 32'h1FF);
    bus_stop();
    cur_read(pat(4), "R2 pointer untouched by wrong code");
  endtask

  task automatic t_write_data();
    logic ack;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h20, ack);
    send_byte(8'h00, ack);
    chk(!ack, "R12 data byte not acked", 32'(ack), 0);
    bus_stop();
    rand_read(8'h20, pat(8'h20), "R12 array unchanged");
  endtask

  task automatic t_abort();
    logic ack;
    logic [7:0] v;
    bus_start();
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    bus_stop();
    chk(sda_oe == 1'b0, "R10 stop mid byte releases", 32'(sda_oe), 0);
    bus_start();
    send_byte(8'hA0, ack);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    bus_start();
    send_byte(8'hA1, ack);
    chk(ack, "R10 restart mid byte accepted", 32'(ack), 1);
    recv_byte(1'b0, v);
    chk(v == pat(8'h21), "R10 partial word address ignored", 32'(v), 32'(pat(8'h21)));
    bus_stop();
  endtask

  task automatic t_load_port();
    mem_load(7'h40, 8'h5A);
    rand_read(8'h40, 8'h5A, "R13 load port write visible");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 128; i++) mem_load(7'(i), pat(i));
    hold();
    t_reset_and_current();
    t_random();
    t_dummy_write();
    t_sequential();
    t_device_code();
    t_write_data();
    t_abort();
    t_load_port();
    chk(oe_viol == 0, "R11 drive changes with SCL low", 32'(oe_viol), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule